// File: doc/BRIEF.md
# Serial-In Latched Parallel Output Expander

This block turns a serial bit stream into a parallel word that drives a bank of outputs. Bits enter a shift register on the rising clock edge while the strobe is low. While the strobe is high, shifting stops and the register contents are copied into an output latch. The latch holds that word after the strobe falls, so the parallel outputs stay steady while the next word is shifted in.

An active-low clear presets every latch bit to one without touching the shift register. An output-enable input gates the parallel outputs. When the enable is low, a per-bit valid mask drops, which stands in for a high-impedance state. A serial output carries the last register stage, so several devices can be chained on one data line. The output width is a parameter.

Top module: `sipo_latch_driver`

## Requirements
- R1: On each rising clock edge with `strobe_i` low, bit 0 of the shift register takes `ser_i` and every bit k moves to bit k+1. The first of WIDTH shifted bits therefore lands on `par_o[WIDTH-1]` once latched.
- R2: On a rising edge with `strobe_i` high, the shift register keeps its contents and `ser_o` does not change.
- R3: On a rising edge with `strobe_i` high and `clr_ni` high, the latch takes the shift register value.
- R4: On a rising edge with `strobe_i` low and `clr_ni` high, the latch keeps its value.
- R5: While `clr_ni` is low, every latch bit is 1 at once, without waiting for a clock edge. The clear takes priority over the strobe and leaves the shift register unchanged.
- R6: `ser_o` always equals the highest shift register stage, whatever the strobe does.
- R7: With `oe_i` high, `par_o` equals the latch and every bit of `par_valid_o` is 1. With `oe_i` low, both `par_o` and `par_valid_o` are all 0.
- R8: While `rst_ni` is low, the shift register is all 0 and the latch is all 1.
- R9: The width is set by the parameter WIDTH (for example 8, 12 or 28). Every port that carries a word is WIDTH bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift and latch clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data in |
| strobe_i | input | 1 | High: hold the shift register and load the latch |
| clr_ni | input | 1 | Asynchronous latch preset to all ones, active low |
| oe_i | input | 1 | Parallel output enable |
| par_o | output | WIDTH | Parallel outputs |
| par_valid_o | output | WIDTH | Per-bit drive mask; 0 stands for high impedance |
| ser_o | output | 1 | Cascade output, last shift stage |

## Verification
A clear and a strobe can arrive on the same edge, and so can a clear and a shift. The bench drives random combinations of strobe, clear, enable and data each cycle. It also forces a directed case that holds the clear low with the strobe high, then releases the clear and strobes again. The latch must read all ones during the clear. The later strobe must show the shift register word that was kept through the clear, which confirms that the clear has priority and that the register was left untouched.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  typedef struct packed {
    logic ser;
    logic strobe;
  } shift_ctl_t;
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned WIDTH = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  sipo_pkg::shift_ctl_t  ctl_i,
  output logic [WIDTH-1:0]      sr_o
);
  logic [WIDTH-1:0] sr_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic d;
    if (i == 0) begin : g_head
      assign d = ctl_i.ser;
    end else begin : g_body
      assign d = sr_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            sr_q[i] <= 1'b0;
      else if (!ctl_i.strobe) sr_q[i] <= d;
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/sipo_out_latch.sv
module sipo_out_latch #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] PRESET = '1;
  logic [WIDTH-1:0] q;

  // clear beats strobe; both presets are asynchronous
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni)      q <= PRESET;
    else if (!clr_ni) q <= PRESET;
    else if (load_i)  q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             oe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] vld_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign q_o[i]   = oe_i & d_i[i];
    assign vld_o[i] = oe_i;
  end
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             strobe_i,
  input  logic             clr_ni,
  input  logic             oe_i,
  output logic [WIDTH-1:0] par_o,
  output logic [WIDTH-1:0] par_valid_o,
  output logic             ser_o
);
  localparam int unsigned MSB = WIDTH - 1;

  sipo_pkg::shift_ctl_t ctl;
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] lat_q;

  assign ctl.ser    = ser_i;
  assign ctl.strobe = strobe_i;

  sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .sr_o   (sr_q)
  );

  sipo_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .load_i (strobe_i),
    .d_i    (sr_q),
    .q_o    (lat_q)
  );

  sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_i  (oe_i),
    .d_i   (lat_q),
    .q_o   (par_o),
    .vld_o (par_valid_o)
  );

  assign ser_o = sr_q[MSB];
endmodule

// File: rtl/sipo_latch_driver_chk.sv
module sipo_latch_driver_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_i,
  input logic             strobe_i,
  input logic             clr_ni,
  input logic             oe_i,
  input logic [WIDTH-1:0] par_o,
  input logic [WIDTH-1:0] par_valid_o,
  input logic             ser_o,
  input logic [WIDTH-1:0] sr_i,
  input logic [WIDTH-1:0] lat_i
);
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> sr_i == {$past(sr_i[WIDTH-2:0]), $past(ser_i)}); // R1

  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> $stable(sr_i) && $stable(ser_o)); // R2

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && clr_ni) |=> (!clr_ni || lat_i == $past(sr_i))); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && clr_ni) |=> (!clr_ni || $stable(lat_i))); // R4

  AST_CLEAR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> lat_i == '1); // R5

  AST_CASCADE_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_o == sr_i[WIDTH-1]); // R6

  AST_OE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i ? (par_valid_o == '1 && par_o == lat_i)
         : (par_valid_o == '0 && par_o == '0)); // R7
endmodule

bind sipo_latch_driver sipo_latch_driver_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_i       (ser_i),
  .strobe_i    (strobe_i),
  .clr_ni      (clr_ni),
  .oe_i        (oe_i),
  .par_o       (par_o),
  .par_valid_o (par_valid_o),
  .ser_o       (ser_o),
  .sr_i        (sr_q),
  .lat_i       (lat_q)
);

// File: tb/sipo_latch_driver_tb.sv
`timescale 1ns/1ps
module sipo_latch_driver_tb;
  localparam int unsigned W = 12; // R9: width chosen by parameter
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_i = 1'b0, strobe_i = 1'b0, clr_ni = 1'b1, oe_i = 1'b1;
  logic [W-1:0] par_o, par_valid_o;
  logic ser_o;

  logic [W-1:0] sr_m, lat_m;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sipo_latch_driver #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser_i), .strobe_i(strobe_i),
    .clr_ni(clr_ni), .oe_i(oe_i), .par_o(par_o), .par_valid_o(par_valid_o),
    .ser_o(ser_o)
  );

  function automatic logic [W-1:0] exp_par(input logic [W-1:0] lat, input logic oe);
    return oe ? lat : '0;
  endfunction

  function automatic logic [W-1:0] exp_vld(input logic oe);
    return oe ? ONES : '0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    string rq;
    rq = !clr_ni ? "R5" : "R3/R4";
    if (!oe_i) rq = "R7";
    check(rq, par_o, exp_par(lat_m, oe_i));
    check("R7", par_valid_o, exp_vld(oe_i));
    check("R6", W'(ser_o), W'(sr_m[W-1]));
  endtask

  task automatic step(input logic s, input logic stb, input logic clr, input logic oe);
    @(negedge clk);
    ser_i = s; strobe_i = stb; clr_ni = clr; oe_i = oe;
    if (!clr) lat_m = ONES;
    #1;
    if (!clr) check("R5 async", par_o, exp_par(ONES, oe));
    @(posedge clk);
    if (!clr)      lat_m = ONES;
    else if (stb)  lat_m = sr_m;
    if (!stb) sr_m = {sr_m[W-2:0], s};
    #1;
    check_all();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    logic prev;
    void'($urandom(32'h5150_0C0D));
    sr_m = '0; lat_m = ONES;
    repeat (3) @(posedge clk);
    #1;
    check("R8 latch", par_o, ONES);
    check("R8 shift", W'(ser_o), '0);
    @(negedge clk); rst_ni = 1'b1;

    // R1: first shifted bit ends on the top output
    word = W'(12'hA5C);
    for (int i = W - 1; i >= 0; i--) step(word[i], 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    check("R1 order", par_o, word);

    // R2: strobe high freezes shifting while ser_i toggles
    prev = ser_o;
    for (int i = 0; i < 4; i++) step(i[0], 1'b1, 1'b1, 1'b1);
    check("R2 hold", W'(ser_o), W'(prev));

    // R4: strobe low, latch unchanged while new data shifts
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, 1'b1);
    check("R4 hold", par_o, word);

    // R5: clear with strobe high, shift register kept
    step(1'b0, 1'b1, 1'b0, 1'b1);
    check("R5 prio", par_o, ONES);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    check("R5 sr kept", par_o, sr_m);

    // R7: enable low masks outputs
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 off", par_valid_o, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom), ($urandom % 4) == 0, ($urandom % 10) != 0, ($urandom % 6) != 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule